// File: doc/BRIEF.md
# Alternating-Bit Link Receiver

This block is the receiving end of an alternating-bit link. Frames reach it through a one-slot incoming channel register that sits outside the block. Each frame carries a 2-bit tag and a payload word. The block keeps an expected sequence bit. A frame whose sequence bit equals the expected bit has its payload captured and handed to the user as a one-cycle strobe. After that the expected bit flips.

A frame with the wrong sequence bit is treated as a duplicate. A frame marked corrupt is treated the same way. Neither is delivered, but each still causes an acknowledgement. Every acknowledgement carries the complement of the current expected bit, so it always names the last frame that was accepted. The acknowledgement goes into a one-slot return channel register, also outside the block. The block writes it only when that slot reports empty, and it waits for as long as the slot stays full.

While the block is in its receive state it empties the incoming slot on every cycle through a clear output.

Top module: `altbit_receiver`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters its receive state with expected bit 0. In that state `in_clear`=1, `dlv_valid`=0 and `ack_we`=0.
- R2: The tag encoding is 0 = empty, 1 = frame with sequence bit 0, 2 = frame with sequence bit 1, 3 = corrupt. In the receive state, tag 1 with expected bit 0, or tag 2 with expected bit 1, captures `in_data`. On the next cycle `dlv_valid`=1 and `dlv_data` equals the captured word.
- R3: In the receive state, tag 3, or a frame whose sequence bit differs from the expected bit, produces no delivery. The block goes straight to the acknowledge state on the next cycle.
- R4: In the receive state, tag 0 keeps the block in the receive state.
- R5: `in_clear` is 1 on every cycle the block is in the receive state and 0 in every other state.
- R6: The deliver state lasts exactly one cycle, with `dlv_valid`=1. It is followed by the acknowledge state, and the expected bit is inverted.
- R7: In the acknowledge state with `ack_empty`=1, the block raises `ack_we` for one cycle with `ack_bit` equal to the inverse of the expected bit (0 means ack0), then returns to receive. With `ack_empty`=0 it stays in the acknowledge state and `ack_we`=0.
- R8: `dlv_data` changes only on a cycle after a frame was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_tag | input | 2 | Tag held in the incoming slot |
| in_data | input | DATA_W | Payload held in the incoming slot |
| in_clear | output | 1 | Empties the incoming slot at the next edge |
| dlv_valid | output | 1 | One-cycle delivery strobe to the user |
| dlv_data | output | DATA_W | Delivered payload word |
| ack_empty | input | 1 | Return slot is empty |
| ack_we | output | 1 | Writes the acknowledgement into the return slot |
| ack_bit | output | 1 | Acknowledgement value (0 = ack0, 1 = ack1) |

## Verification
The bench aims at runs of duplicates and corrupt frames after an accepted one. A design that accepted on the wrong bit, or that toggled without delivering, would strobe `dlv_valid` for a repeated frame, or would acknowledge with a value that skips a frame. A long stall of the return slot is also driven. A design that wrote early would raise `ack_we` while the slot was full, and a design that dropped the wait would return to receive without writing. Random tags and slot availability are mixed in, so every state is entered with every input combination, and an empty tag must hold the receive state with `in_clear` still raised.

// File: rtl/altbit_pkg.sv
package altbit_pkg;
  typedef enum logic [1:0] {
    TAG_EMPTY   = 2'd0,
    TAG_SEQ0    = 2'd1,
    TAG_SEQ1    = 2'd2,
    TAG_CORRUPT = 2'd3
  } slot_tag_t;

  typedef enum logic [1:0] {
    ST_RECEIVE  = 2'd0,
    ST_DELIVER  = 2'd1,
    ST_SEND_ACK = 2'd2
  } rx_state_t;
endpackage

// File: rtl/altbit_ctrl.sv
module altbit_ctrl
  import altbit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_tag_t tag_i,
  input  logic      ack_empty_i,
  output rx_state_t state_o,
  output logic      exp_bit_o,
  output logic      accept_o
);
  rx_state_t state_q, state_d;
  logic      exp_q;
  logic      match, reject;

  always_comb begin
    match  = (tag_i == TAG_SEQ0 && !exp_q) || (tag_i == TAG_SEQ1 && exp_q);
    reject = (tag_i == TAG_CORRUPT) ||
             (tag_i == TAG_SEQ0 && exp_q) || (tag_i == TAG_SEQ1 && !exp_q);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RECEIVE: begin
        if (match)       state_d = ST_DELIVER;
        else if (reject) state_d = ST_SEND_ACK;
      end
      ST_DELIVER:  state_d = ST_SEND_ACK;
      ST_SEND_ACK: if (ack_empty_i) state_d = ST_RECEIVE;
      default:     state_d = ST_RECEIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RECEIVE;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DELIVER) exp_q <= ~exp_q;
    end
  end

  assign state_o   = state_q;
  assign exp_bit_o = exp_q;
  assign accept_o  = (state_q == ST_RECEIVE) && match;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (state_q == ST_RECEIVE && !exp_q)); // R1
  AST_ACCEPT_TO_DELIVER: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> state_q == ST_DELIVER); // R2
  AST_BAD_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECEIVE && tag_i == TAG_CORRUPT) |=> state_q == ST_SEND_ACK); // R3
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECEIVE && tag_i == TAG_EMPTY) |=> state_q == ST_RECEIVE); // R4
  AST_DELIVER_ONCE: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_DELIVER |=> (state_q == ST_SEND_ACK && exp_q != $past(exp_q))); // R6
  AST_ACK_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND_ACK && !ack_empty_i) |=> (state_q == ST_SEND_ACK && $stable(exp_q))); // R7
endmodule

// File: rtl/altbit_capture.sv
module altbit_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) word_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = word_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R6
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(word_q)); // R8
endmodule

// File: rtl/altbit_ack.sv
module altbit_ack
  import altbit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rx_state_t state_i,
  input  logic      exp_bit_i,
  input  logic      empty_i,
  output logic      we_o,
  output logic      bit_o
);
  always_comb begin
    we_o  = (state_i == ST_SEND_ACK) && empty_i;
    bit_o = ~exp_bit_i;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o); // R7
endmodule

// File: rtl/altbit_receiver.sv
module altbit_receiver
  import altbit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_clear,
  output logic              dlv_valid,
  output logic [DATA_W-1:0] dlv_data,
  input  logic              ack_empty,
  output logic              ack_we,
  output logic              ack_bit
);
  rx_state_t state;
  logic      exp_bit;
  logic      accept;

  altbit_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tag_i      (slot_tag_t'(in_tag)),
    .ack_empty_i(ack_empty),
    .state_o    (state),
    .exp_bit_o  (exp_bit),
    .accept_o   (accept)
  );

  altbit_capture #(.DATA_W(DATA_W)) i_capture (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .data_i (in_data),
    .valid_o(dlv_valid),
    .data_o (dlv_data)
  );

  altbit_ack i_ack (
    .clk      (clk),
    .rst      (rst),
    .state_i  (state),
    .exp_bit_i(exp_bit),
    .empty_i  (ack_empty),
    .we_o     (ack_we),
    .bit_o    (ack_bit)
  );

  assign in_clear = (state == ST_RECEIVE);

  AST_CLEAR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    in_clear |-> (!dlv_valid && !ack_we)); // R5
endmodule

// File: tb/test_altbit_receiver.sv
`timescale 1ns/1ps
module test_altbit_receiver;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] in_tag = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic ack_empty = 1'b0;
  logic in_clear, dlv_valid, ack_we, ack_bit;
  logic [DW-1:0] dlv_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_st = 0;
  bit m_exp = 1'b0;
  logic [DW-1:0] m_cap = '0;
  string lbl = "R1";

  always #2.5 clk = ~clk;

  altbit_receiver #(.DATA_W(DW)) i_altbit_receiver (
    .clk(clk), .rst(rst), .in_tag(in_tag), .in_data(in_data),
    .in_clear(in_clear), .dlv_valid(dlv_valid), .dlv_data(dlv_data),
    .ack_empty(ack_empty), .ack_we(ack_we), .ack_bit(ack_bit)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit is_match(input logic [1:0] t, input bit e);
    return (t == 2'd1 && !e) || (t == 2'd2 && e);
  endfunction

  task automatic step(input logic [1:0] t, input logic [DW-1:0] d, input bit emp);
    int nst;
    bit nexp;
    logic [DW-1:0] ncap;
    string nl;
    @(negedge clk);
    in_tag = t; in_data = d; ack_empty = emp;
    #1;
    check({lbl, "/R5 clear"}, in_clear, m_st == 0);
    check({lbl, "/R6 valid"}, dlv_valid, m_st == 1);
    if (m_st == 1) check("R2/R8 data", dlv_data, m_cap);
    check("R7 ack_we", ack_we, (m_st == 2) && emp);
    if (m_st == 2 && emp) check("R7 ack_bit", ack_bit, !m_exp);
    nst = m_st; nexp = m_exp; ncap = m_cap; nl = "R7";
    case (m_st)
      0: begin
        if (t == 2'd0) nl = "R4";
        else if (is_match(t, m_exp)) begin ncap = d; nst = 1; nl = "R2"; end
        else begin nst = 2; nl = "R3"; end
      end
      1: begin nexp = !m_exp; nst = 2; nl = "R6"; end
      default: if (emp) nst = 0;
    endcase
    @(posedge clk);
    m_st = nst; m_exp = nexp; m_cap = ncap; lbl = nl;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 clear", in_clear, 1);
    check("R1 valid", dlv_valid, 0);
    check("R1 ack_we", ack_we, 0);
    // directed: accept bit0, duplicate, corrupt, stalled ack
    step(2'd1, 8'hA5, 1'b1);
    step(2'd0, 8'h00, 1'b1);
    step(2'd0, 8'h00, 1'b0);
    step(2'd0, 8'h00, 1'b0);
    step(2'd0, 8'h00, 1'b0);
    step(2'd0, 8'h00, 1'b1);
    step(2'd1, 8'h11, 1'b1);   // duplicate of accepted bit 0
    step(2'd0, 8'h00, 1'b1);
    step(2'd3, 8'h22, 1'b0);   // corrupt
    step(2'd0, 8'h00, 1'b1);
    step(2'd0, 8'h00, 1'b1);   // empty hold
    step(2'd2, 8'h5A, 1'b1);   // accept bit1
    step(2'd0, 8'h00, 1'b1);
    step(2'd0, 8'h00, 1'b1);
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++)
      step(2'($urandom_range(0, 3)), 8'($urandom), 1'($urandom_range(0, 1)));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule